// File: doc/BRIEF.md
# Cross-domain configuration register with busy flag

This block is an 8-bit control and status register that software writes from a processor clock domain. Its low four bits are settings for a receive datapath that runs on its own, unrelated clock. Every accepted write copies the new settings into a source-side holding register. A four-phase request/acknowledge handshake then carries them into the receive domain. While the transfer is in flight the register reports itself busy and drops any further write. The settings appear on the receive-side output only when the handshake loads them there.

Software polls the busy bit, writes once, and polls again until busy returns to 0. A global receiver enable is the only way to abandon a transfer that has started. Pulling the enable low returns the writable bits to their reset value of all ones, clears the busy state and withdraws the request. Once the enable has crossed into the receive domain, the same event also returns the receive-side settings to all ones. Three status flags produced in the receive domain are passed back through synchronizers and read in the upper bits of the register.

The write side is a plain strobe with a data word and needs no valid/ready handshake. Back-pressure is expressed only through the busy bit: a strobe seen while busy is dropped, not queued.

Top module: `rxcfg_push_reg`

## Requirements
- R1: After reset, rd_data reads 0x0F: bit 7 (busy) is 0, bits 6..4 reflect the synchronized status, bits 3..0 are 1. cfg_out is 4'hF.
- R2: A wr_en strobe while idle and enabled is accepted. On the next processor clock, rd_data[3:0] equals wr_data[3:0] and rd_data[7] is 1. wr_data[7:4] has no effect on any register bit.
- R3: A wr_en strobe while rd_data[7] is 1 is ignored: rd_data[3:0] and the value later delivered on cfg_out stay those of the accepted write.
- R4: cfg_out changes only when a transfer completes or the receiver is disabled. In the processor clock after an accepted write, cfg_out still holds the previous settings.
- R5: rd_data[7] returns to 0 one processor clock after the synchronized acknowledge is seen. At that point cfg_out already equals the accepted settings. Each transfer finishes within 40 processor clocks.
- R6: rd_data[6:4] equals rx_status[2:0] (bit 6 = rx_status[2]) once the status has been steady for 4 processor clocks.
- R7: While rx_enable is 0, rd_data[7] is 0 and rd_data[3:0] is 4'hF one processor clock after the drop. Writes have no effect, and cfg_out returns to 4'hF within a few receive clocks.
- R8: The request rises only while the synchronized acknowledge is low, and falls only after the acknowledge is seen or on abort. The held data word is stable while the request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-domain clock |
| cpu_rst_n | input | 1 | Active-low reset, processor domain |
| rx_enable | input | 1 | Global receiver enable; low aborts and resets the register |
| wr_en | input | 1 | Write strobe, one processor clock per write |
| wr_data | input | 8 | Write data; only bits 3..0 are stored |
| rd_data | output | 8 | {busy, synchronized status[2:0], settings[3:0]} |
| rx_clk | input | 1 | Receive-domain clock |
| rx_rst_n | input | 1 | Active-low reset, receive domain |
| rx_status | input | 3 | Status flags produced in the receive domain |
| cfg_out | output | 4 | Settings as delivered to the receive domain |

## Verification
The bench builds the block with its default parameters: four settings bits, three status bits and two synchronizer stages. At this size the whole 8-bit write word can be swept, with all 256 codes written back to back so that each new write can land while the previous acknowledge is still high. Every one of the eight status codes is also driven through the return path. The clocks are unrelated: the receive clock has a 14 ns period against the 20 ns processor clock, so the synchronizer phase drifts through the sweep. An abort mid-transfer, writes attempted while disabled, and a clean restart after re-enable are covered as well.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_DRAIN = 2'd1,
    SRC_REQ   = 2'd2
  } src_state_e;
endpackage

// File: rtl/rxcfg_sync.sv
module rxcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rxcfg_src.sv
module rxcfg_src
  import rxcfg_pkg::*;
#(
  parameter int           CFG_W   = 4,
  parameter logic [CFG_W-1:0] CFG_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             ack_s,
  output logic             req,
  output logic [CFG_W-1:0] hold,
  output logic             busy
);
  src_state_e   state_q;
  logic         req_q;
  logic [CFG_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      hold_q  <= CFG_RST;
    end else if (!enable) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      hold_q  <= CFG_RST;
    end else begin
      unique case (state_q)
        SRC_IDLE: if (wr_en) begin
          hold_q <= wr_data;
          if (ack_s) state_q <= SRC_DRAIN;
          else begin
            state_q <= SRC_REQ;
            req_q   <= 1'b1;
          end
        end
        SRC_DRAIN: if (!ack_s) begin
          state_q <= SRC_REQ;
          req_q   <= 1'b1;
        end
        SRC_REQ: if (ack_s) begin
          state_q <= SRC_IDLE;
          req_q   <= 1'b0;
        end
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

  assign req  = req_q;
  assign hold = hold_q;
  assign busy = (state_q != SRC_IDLE);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && $past(req_q) |-> $stable(hold_q));

  // R8
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_s));

  // R8
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> ($past(ack_s) || !$past(enable)));

  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(enable) |-> $past(ack_s));

  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && enable |=> $stable(hold_q));
endmodule

// File: rtl/rxcfg_dst.sv
module rxcfg_dst #(
  parameter int               CFG_W   = 4,
  parameter logic [CFG_W-1:0] CFG_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             req_s,
  input  logic [CFG_W-1:0] data_in,
  output logic             ack,
  output logic [CFG_W-1:0] cfg_out
);
  logic             ack_q;
  logic [CFG_W-1:0] cfg_q;
  logic             load;

  assign load = req_s && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cfg_q <= CFG_RST;
    end else begin
      ack_q <= req_s;
      if (!en_s)     cfg_q <= CFG_RST;
      else if (load) cfg_q <= data_in;
    end
  end

  assign ack     = ack_q;
  assign cfg_out = cfg_q;

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_s) && !$past(load) |-> $stable(cfg_q));

  // R7
  cfg_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_s) |-> (cfg_q == CFG_RST));
endmodule

// File: rtl/rxcfg_push_reg.sv
module rxcfg_push_reg #(
  parameter int CFG_W       = 4,
  parameter int STAT_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] CFG_RST = '1,
  localparam int DATA_W = 1 + STAT_W + CFG_W
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              rx_enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic [STAT_W-1:0] rx_status,
  output logic [CFG_W-1:0]  cfg_out
);
  logic             req, ack, req_s, ack_s, en_s, busy;
  logic [CFG_W-1:0] hold;
  logic [STAT_W-1:0] stat_s;

  rxcfg_src #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_src (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .enable(rx_enable),
    .wr_en(wr_en), .wr_data(wr_data[CFG_W-1:0]), .ack_s(ack_s),
    .req(req), .hold(hold), .busy(busy)
  );

  rxcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack), .q(ack_s));

  rxcfg_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(rx_status), .q(stat_s));

  rxcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(req), .q(req_s));

  rxcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(rx_enable), .q(en_s));

  rxcfg_dst #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_dst (
    .clk(rx_clk), .rst_n(rx_rst_n), .en_s(en_s), .req_s(req_s),
    .data_in(hold), .ack(ack), .cfg_out(cfg_out)
  );

  assign rd_data = {busy, stat_s, hold};

  // R7
  abort_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !$past(rx_enable) |-> (!busy && hold == CFG_RST));

  // R2
  accept_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !busy && wr_en && rx_enable |=> busy && hold == $past(wr_data[CFG_W-1:0]));
endmodule

// File: tb/rxcfg_push_reg_tb.sv
`timescale 1ns/1ps
module rxcfg_push_reg_tb;
  logic       cpu_clk = 0, rx_clk = 0;
  logic       cpu_rst_n = 0, rx_rst_n = 0;
  logic       rx_enable = 1, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] rx_status = '0;
  logic [3:0] cfg_out;
  int errors = 0, checks = 0;

  always #10 cpu_clk = ~cpu_clk;
  always #7  rx_clk  = ~rx_clk;

  rxcfg_push_reg u_dut (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .rx_enable(rx_enable),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_status(rx_status),
    .cfg_out(cfg_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 40; i++) begin
      if (rd_data[7] == 1'b0) begin ok = 1; break; end
      @(negedge cpu_clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge cpu_clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [3:0] prev;
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 1; rx_rst_n = 1;
    repeat (4) @(negedge cpu_clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h0F);
    check("R1 cfg_out", cfg_out, 4'hF);

    // R2..R5 exhaustive write sweep, back to back
    prev = 4'hF;
    for (int v = 0; v < 256; v++) begin
      wr_en = 1; wr_data = v[7:0];
      @(negedge cpu_clk);
      wr_en = 0;
      check("R2 accepted", rd_data, {1'b1, 3'b000, v[3:0]});
      check("R4 old cfg", cfg_out, prev);
      // R3 blocked write
      wr_en = 1; wr_data = ~v[7:0];
      @(negedge cpu_clk);
      wr_en = 0;
      check("R3 blocked", rd_data[3:0], v[3:0]);
      wait_idle(ok);
      check("R5 completes", ok, 1);
      check("R5 cfg at done", cfg_out, v[3:0]);
      check("R3 final rd", rd_data, {1'b0, 3'b000, v[3:0]});
      prev = v[3:0];
    end

    // R6 status sweep
    for (int s = 0; s < 8; s++) begin
      @(negedge rx_clk);
      rx_status = s[2:0];
      repeat (4) @(negedge cpu_clk);
      check("R6 status", rd_data[6:4], s[2:0]);
    end
    @(negedge rx_clk); rx_status = 3'b000;
    repeat (4) @(negedge cpu_clk);

    // R7 abort mid-transfer
    wr_en = 1; wr_data = 8'h05;
    @(negedge cpu_clk);
    wr_en = 0; rx_enable = 0;
    @(negedge cpu_clk);
    check("R7 abort rd", rd_data, 8'h0F);
    wr_en = 1; wr_data = 8'h03;
    @(negedge cpu_clk);
    wr_en = 0;
    check("R7 write ignored", rd_data, 8'h0F);
    repeat (10) @(negedge cpu_clk);
    check("R7 cfg reset", cfg_out, 4'hF);
    check("R7 still idle", rd_data, 8'h0F);
    rx_enable = 1;
    repeat (10) @(negedge cpu_clk);
    wr_en = 1; wr_data = 8'hA6;
    @(negedge cpu_clk);
    wr_en = 0;
    check("R7 restart accepted", rd_data, 8'h86);
    wait_idle(ok);
    check("R7 restart done", ok, 1);
    check("R7 restart cfg", cfg_out, 4'h6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule